// File: doc/BRIEF.md
# Registered Cascadable Arithmetic and Logic Unit

A word-wide arithmetic and logic unit for datapaths that chain several such units into longer words. Two operands pass through optional input registers, then an operand selector, then the ALU proper. The result goes through an optional result register and an output-enable gate. A 3-bit opcode picks one of eight functions: constant zero, two inverted-operand adds, a plain add, three bitwise functions and constant ones. With the carry input held at 1, the two inverted-operand adds give the two subtraction orders.

Each input register and the result register has its own load enable. One control bypasses both input registers and a second one bypasses the result register, so the unit can run fully combinational, fully pipelined, or anywhere between. Each operand has its own 2-bit source select. It can take the external or registered operand, or the registered result (for accumulation and chained operations), or zero (for unary operations). Word-level lookahead propagate and generate, the carry-out, a signed overflow flag and a zero flag let an external carry generator or a ripple chain join several slices.

Top module: `cascade_alu`

## Requirements
- R1: Opcode 3'b011 gives A+B+cin, 3'b001 gives NOT(A)+B+cin, and 3'b010 gives A+NOT(B)+cin, each taken modulo 2^W. With cin=1, 3'b001 yields B-A and 3'b010 yields A-B.
- R2: Opcode 3'b000 gives all zeros, 3'b100 gives A XOR B, 3'b101 gives A OR B, 3'b110 gives A AND B and 3'b111 gives all ones; the carry input has no effect on these codes.
- R3: The A and B input registers load a_in and b_in on a rising clock edge only while a_load or b_load is 1, respectively, and hold otherwise. While in_bypass is 1, the ALU uses a_in and b_in directly, with no clock edge needed.
- R4: The result register loads the ALU output on a rising edge only while f_load is 1. While out_bypass is 1, the ALU output reaches f_out combinationally; otherwise f_out shows the result register.
- R5: Each operand source select (a_src, b_src) works as follows: 2'b00 takes the external or registered operand, 2'b01 takes the result register contents, and 2'b1x forces the operand to zero.
- R6: While oe is 0, f_out is all zeros. This models a released bus.
- R7: For the arithmetic codes, with x and y the two adder inputs after any inversion, prop is the AND over all bits of (x OR y), gen is the carry-out of x+y with zero carry-in, and cout equals gen OR (prop AND cin).
- R8: For the arithmetic codes, ovf is 1 exactly when x and y have the same sign bit and the sum's sign bit differs from it.
- R9: For opcodes 3'b000, 3'b100, 3'b101, 3'b110 and 3'b111, cout, ovf, prop and gen are all 0.
- R10: zero is 1 exactly when the ALU output ahead of the result register is all zeros. It does not depend on oe or on the result register.
- R11: A synchronous active-high rst clears the A, B and result registers to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for all registers |
| rst | input | 1 | Synchronous active-high reset |
| a_in | input | W | External operand A |
| b_in | input | W | External operand B |
| opcode | input | 3 | Function select |
| cin | input | 1 | Carry input of the slice |
| a_load | input | 1 | Load enable of the A register |
| b_load | input | 1 | Load enable of the B register |
| f_load | input | 1 | Load enable of the result register |
| in_bypass | input | 1 | Route a_in/b_in around the input registers |
| out_bypass | input | 1 | Route the ALU output around the result register |
| a_src | input | 2 | Source select for operand A |
| b_src | input | 2 | Source select for operand B |
| oe | input | 1 | Output enable of f_out |
| f_out | output | W | Result |
| prop | output | 1 | Word lookahead propagate |
| gen | output | 1 | Word lookahead generate |
| cout | output | 1 | Carry-out |
| ovf | output | 1 | Signed overflow |
| zero | output | 1 | ALU output is all zeros |

## Verification
The bench builds the unit at its default width W=16. At that width the sign-bit overflow cases (0x7FFF+1, 0x8000-1), the full-word propagate of 0xFFFF against 0x0000, and the wrap of 0xFFFF+1 can all be written as literal vectors. Those vectors also give carry-out in both states and expose the carry-in dependence of cout. The bypass settings let the vector table run combinationally. The directed part then works through the register path: hold versus load, accumulation through the feedback source, forced-zero operands and the gated output.

// File: rtl/alu_pkg.sv
package alu_pkg;
  typedef enum logic [2:0] {
    OP_CLEAR  = 3'b000,
    OP_NA_B   = 3'b001,
    OP_A_NB   = 3'b010,
    OP_ADD    = 3'b011,
    OP_XOR    = 3'b100,
    OP_OR     = 3'b101,
    OP_AND    = 3'b110,
    OP_PRESET = 3'b111
  } alu_op_e;

  localparam logic [1:0] SRC_PORT = 2'b00;
  localparam logic [1:0] SRC_FEED = 2'b01;

  localparam int NUM_OPERANDS = 2;
endpackage

// File: rtl/operand_stage.sv
module operand_stage #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic         bypass,
  input  logic [1:0]   src,
  input  logic [W-1:0] ext,
  input  logic [W-1:0] feedback,
  output logic [W-1:0] operand
);
  import alu_pkg::*;

  logic [W-1:0] held;
  logic [W-1:0] staged;

  always_ff @(posedge clk) begin
    if (rst)       held <= '0;
    else if (load) held <= ext;
  end

  assign staged = bypass ? ext : held;

  always_comb begin
    if (src[1])               operand = '0;
    else if (src == SRC_FEED) operand = feedback;
    else                      operand = staged;
  end
endmodule

// File: rtl/alu_core.sv
module alu_core #(
  parameter int W = 16
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic [2:0]   op,
  input  logic         cin,
  output logic [W-1:0] f,
  output logic         prop,
  output logic         gen,
  output logic         cout,
  output logic         ovf,
  output logic         zero
);
  import alu_pkg::*;

  logic [W-1:0] x, y;
  logic [W:0]   sum;
  logic [W:0]   sum_nc;
  logic         arith;

  always_comb begin
    arith = 1'b1;
    x     = a;
    y     = b;
    case (alu_op_e'(op))
      OP_NA_B: x = ~a;
      OP_A_NB: y = ~b;
      OP_ADD:  ;
      default: arith = 1'b0;
    endcase
  end

  assign sum    = {1'b0, x} + {1'b0, y} + {{W{1'b0}}, cin};
  assign sum_nc = {1'b0, x} + {1'b0, y};

  always_comb begin
    f = sum[W-1:0];
    case (alu_op_e'(op))
      OP_CLEAR:  f = '0;
      OP_XOR:    f = a ^ b;
      OP_OR:     f = a | b;
      OP_AND:    f = a & b;
      OP_PRESET: f = '1;
      default:   f = sum[W-1:0];
    endcase
  end

  assign prop = arith & (&(x | y));
  assign gen  = arith & sum_nc[W];
  assign cout = gen | (prop & cin);
  assign ovf  = arith & (x[W-1] == y[W-1]) & (sum[W-1] != x[W-1]);
  assign zero = (f == '0);
endmodule

// File: rtl/result_stage.sv
module result_stage #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic         bypass,
  input  logic         oe,
  input  logic [W-1:0] alu_f,
  output logic [W-1:0] held,
  output logic [W-1:0] f_out
);
  always_ff @(posedge clk) begin
    if (rst)       held <= '0;
    else if (load) held <= alu_f;
  end

  assign f_out = oe ? (bypass ? alu_f : held) : '0;
endmodule

// File: rtl/cascade_alu.sv
module cascade_alu #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] a_in,
  input  logic [W-1:0] b_in,
  input  logic [2:0]   opcode,
  input  logic         cin,
  input  logic         a_load,
  input  logic         b_load,
  input  logic         f_load,
  input  logic         in_bypass,
  input  logic         out_bypass,
  input  logic [1:0]   a_src,
  input  logic [1:0]   b_src,
  input  logic         oe,
  output logic [W-1:0] f_out,
  output logic         prop,
  output logic         gen,
  output logic         cout,
  output logic         ovf,
  output logic         zero
);
  import alu_pkg::*;

  logic [NUM_OPERANDS-1:0][W-1:0] ext_v;
  logic [NUM_OPERANDS-1:0][W-1:0] opd_v;
  logic [NUM_OPERANDS-1:0][1:0]   src_v;
  logic [NUM_OPERANDS-1:0]        load_v;
  logic [W-1:0]                   alu_f;
  logic [W-1:0]                   f_held;

  assign ext_v  = {b_in, a_in};
  assign src_v  = {b_src, a_src};
  assign load_v = {b_load, a_load};

  for (genvar i = 0; i < NUM_OPERANDS; i++) begin : g_opd
    operand_stage #(.W(W)) u_stage (
      .clk      (clk),
      .rst      (rst),
      .load     (load_v[i]),
      .bypass   (in_bypass),
      .src      (src_v[i]),
      .ext      (ext_v[i]),
      .feedback (f_held),
      .operand  (opd_v[i])
    );
  end

  alu_core #(.W(W)) u_core (
    .a    (opd_v[0]),
    .b    (opd_v[1]),
    .op   (opcode),
    .cin  (cin),
    .f    (alu_f),
    .prop (prop),
    .gen  (gen),
    .cout (cout),
    .ovf  (ovf),
    .zero (zero)
  );

  result_stage #(.W(W)) u_res (
    .clk    (clk),
    .rst    (rst),
    .load   (f_load),
    .bypass (out_bypass),
    .oe     (oe),
    .alu_f  (alu_f),
    .held   (f_held),
    .f_out  (f_out)
  );
endmodule

// File: rtl/alu_chk.sv
module alu_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst,
  input logic [2:0]   opcode,
  input logic         cin,
  input logic         f_load,
  input logic         out_bypass,
  input logic         oe,
  input logic [W-1:0] f_out,
  input logic         prop,
  input logic         gen,
  input logic         cout,
  input logic         ovf,
  input logic         zero
);
  logic is_logic;
  assign is_logic = (opcode == 3'b000) || opcode[2];

  // R6
  gated_output_chk: assert property (@(posedge clk) disable iff (rst)
    !oe |-> (f_out == '0));

  // R4
  result_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!out_bypass && oe && !$past(f_load) && !$past(out_bypass) && $past(oe))
      |-> $stable(f_out));

  // R10
  zero_flag_chk: assert property (@(posedge clk) disable iff (rst)
    (out_bypass && oe) |-> (zero == (f_out == '0)));

  // R9
  logic_flags_chk: assert property (@(posedge clk) disable iff (rst)
    is_logic |-> (!cout && !ovf && !prop && !gen));

  // R7
  carry_relation_chk: assert property (@(posedge clk) disable iff (rst)
    !is_logic |-> (cout == (gen | (prop & cin))));

  // R2
  const_codes_chk: assert property (@(posedge clk) disable iff (rst)
    (out_bypass && oe && opcode == 3'b111) |-> (f_out == '1));
endmodule

bind cascade_alu alu_chk #(.W(W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .opcode     (opcode),
  .cin        (cin),
  .f_load     (f_load),
  .out_bypass (out_bypass),
  .oe         (oe),
  .f_out      (f_out),
  .prop       (prop),
  .gen        (gen),
  .cout       (cout),
  .ovf        (ovf),
  .zero       (zero)
);

// File: tb/tb_cascade_alu.sv
module tb_cascade_alu;
  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst;
  logic [W-1:0] a_in, b_in;
  logic [2:0]   opcode;
  logic         cin, a_load, b_load, f_load, in_bypass, out_bypass, oe;
  logic [1:0]   a_src, b_src;
  logic [W-1:0] f_out;
  logic         prop, gen, cout, ovf, zero;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  cascade_alu #(.W(W)) dut (
    .clk(clk), .rst(rst), .a_in(a_in), .b_in(b_in), .opcode(opcode),
    .cin(cin), .a_load(a_load), .b_load(b_load), .f_load(f_load),
    .in_bypass(in_bypass), .out_bypass(out_bypass), .a_src(a_src),
    .b_src(b_src), .oe(oe), .f_out(f_out), .prop(prop), .gen(gen),
    .cout(cout), .ovf(ovf), .zero(zero)
  );

  // {op, cin, a, b, f, cout, ovf, zero}
  localparam int NV = 11;
  localparam logic [54:0] VEC [NV] = '{
    {3'b011, 1'b0, 16'h0001, 16'h0002, 16'h0003, 1'b0, 1'b0, 1'b0},
    {3'b011, 1'b0, 16'hFFFF, 16'h0001, 16'h0000, 1'b1, 1'b0, 1'b1},
    {3'b011, 1'b0, 16'h7FFF, 16'h0001, 16'h8000, 1'b0, 1'b1, 1'b0},
    {3'b010, 1'b1, 16'h0005, 16'h0003, 16'h0002, 1'b1, 1'b0, 1'b0},
    {3'b001, 1'b1, 16'h0005, 16'h0003, 16'hFFFE, 1'b0, 1'b0, 1'b0},
    {3'b100, 1'b1, 16'hF0F0, 16'hFF00, 16'h0FF0, 1'b0, 1'b0, 1'b0},
    {3'b101, 1'b0, 16'hF0F0, 16'hFF00, 16'hFFF0, 1'b0, 1'b0, 1'b0},
    {3'b110, 1'b1, 16'hF0F0, 16'hFF00, 16'hF000, 1'b0, 1'b0, 1'b0},
    {3'b000, 1'b1, 16'h1234, 16'h5678, 16'h0000, 1'b0, 1'b0, 1'b1},
    {3'b111, 1'b0, 16'h1234, 16'h5678, 16'hFFFF, 1'b0, 1'b0, 1'b0},
    {3'b010, 1'b1, 16'h8000, 16'h0001, 16'h7FFF, 1'b1, 1'b1, 1'b0}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  initial begin
    #800000;
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst = 1; a_in = '0; b_in = '0; opcode = 3'b000; cin = 0;
    a_load = 0; b_load = 0; f_load = 0; in_bypass = 0; out_bypass = 0;
    a_src = 2'b00; b_src = 2'b00; oe = 1;
    a_in = 16'h1111; b_in = 16'h2222; a_load = 1; b_load = 1; f_load = 1;
    opcode = 3'b011;
    repeat (3) tick();
    a_load = 0; b_load = 0; f_load = 0;
    rst = 0;
    #1;
    // R11: registers cleared; result register shows zero, operands zero
    check("R11 result reg after reset", 32'(f_out), 32'h0);
    out_bypass = 1; #1;
    check("R11 operand regs after reset", 32'(f_out), 32'h0);

    // Table walk, fully combinational
    in_bypass = 1; out_bypass = 1;
    for (int i = 0; i < NV; i++) begin
      {opcode, cin, a_in, b_in} = VEC[i][54:19];
      #1;
      check($sformatf("R1/R2 vec%0d f", i), 32'(f_out), 32'(VEC[i][18:3]));
      check($sformatf("R7 vec%0d cout", i), 32'(cout), 32'(VEC[i][2]));
      check($sformatf("R8 vec%0d ovf", i), 32'(ovf), 32'(VEC[i][1]));
      check($sformatf("R10 vec%0d zero", i), 32'(zero), 32'(VEC[i][0]));
      if (opcode == 3'b000 || opcode[2])
        check($sformatf("R9 vec%0d p/g", i), 32'({prop, gen}), 32'h0);
    end

    // R2: carry input ignored by logic code
    opcode = 3'b100; a_in = 16'h00FF; b_in = 16'h0F0F; cin = 0; #1;
    check("R2 xor cin0", 32'(f_out), 32'h0FF0);
    cin = 1; #1;
    check("R2 xor cin1", 32'(f_out), 32'h0FF0);

    // R7: full-word propagate and generate
    opcode = 3'b011; a_in = 16'hFFFF; b_in = 16'h0000; cin = 0; #1;
    check("R7 prop all", 32'({prop, gen, cout}), 32'b100);
    cin = 1; #1;
    check("R7 cout via prop", 32'({prop, gen, cout}), 32'b101);
    check("R1 wrap with cin", 32'(f_out), 32'h0);
    a_in = 16'h8000; b_in = 16'h8000; cin = 0; #1;
    check("R7 generate", 32'({prop, gen, cout}), 32'b011);
    check("R8 neg overflow", 32'(ovf), 32'h1);

    // R5: forced-zero operands
    a_in = 16'h1234; b_in = 16'h0007; a_src = 2'b10; #1;
    check("R5 zero A", 32'(f_out), 32'h0007);
    a_src = 2'b00; b_src = 2'b11; #1;
    check("R5 zero B", 32'(f_out), 32'h1234);
    b_src = 2'b00;

    // R3: input register hold and load
    in_bypass = 0; a_in = 16'h0005; b_in = 16'h0001; a_load = 1; b_load = 1;
    tick();
    a_load = 0; b_load = 0; a_in = 16'h0009; b_in = 16'h0009; #1;
    check("R3 regs used", 32'(f_out), 32'h0006);
    tick();
    check("R3 regs hold", 32'(f_out), 32'h0006);
    in_bypass = 1; #1;
    check("R3 bypass", 32'(f_out), 32'h0012);

    // R4/R5: accumulate through feedback
    rst = 1; tick(); rst = 0;
    in_bypass = 0; out_bypass = 0; b_in = 16'h0003; b_load = 1;
    a_src = 2'b01; opcode = 3'b011; cin = 0; f_load = 0;
    tick();
    check("R4 no load keeps zero", 32'(f_out), 32'h0);
    f_load = 1;
    tick();
    check("R5 accumulate 1", 32'(f_out), 32'h0003);
    tick();
    check("R5 accumulate 2", 32'(f_out), 32'h0006);
    f_load = 0;
    tick();
    check("R4 result hold", 32'(f_out), 32'h0006);
    out_bypass = 1; #1;
    check("R4 bypass shows ALU", 32'(f_out), 32'h0009);

    // R6: gated output; R10 zero flag independent of oe
    opcode = 3'b111; oe = 0; #1;
    check("R6 oe low", 32'(f_out), 32'h0);
    check("R10 zero with oe low", 32'(zero), 32'h0);
    oe = 1; #1;
    check("R6 oe high", 32'(f_out), 32'hFFFF);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule